// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block is the transmit half of a synchronous serial port working as a clock slave. The shift clock does not come from inside the chip: another device drives it on an external clock pin. A host writes a byte into a holding register with a one-cycle write strobe. The byte then moves into a shift register, which puts one bit on the data line for each active edge of the external clock. The holding register and the shift register form a double buffer, so a second word can wait while the first one is still shifting.

The external clock is brought into the system clock domain through a flop synchroniser followed by edge detection. A polarity bit chooses whether the data line moves on falling or on rising external edges. Words go out least significant bit first. An optional ninth bit follows them and is captured together with the byte. A buffer-empty flag reports that the holding register is free; it is gated by an enable to form an interrupt or wake request. A shift-empty bit reports that no word is being shifted.

Top module: `sync_slave_tx`

## Requirements
- R1: The transmitter is active only when sync_mode_i=1, port_en_i=1, clk_master_i=0, rx_cont_i=0, rx_single_i=0 and tx_en_i=1. While it is not active, the holding and shift registers are cleared, writes are ignored, data_o is 1 and shift_empty_o is 1, and this holds even in the middle of a word.
- R2: A word written while the shift register is idle moves into the shift register within two clock cycles of the write strobe, and shift_empty_o goes to 0.
- R3: Bit 0 of the word appears on data_o when the word is loaded. Each selected external clock edge then advances data_o by one bit, least significant bit first. The selected edge is the falling edge when clk_pol_i=0 and the rising edge when clk_pol_i=1.
- R4: When nine_bit_i=1 at the write, a ninth bit follows the eight data bits. Its value is bit9_i sampled at the write strobe, and later changes of bit9_i do not affect it.
- R5: A word written while another word is shifting stays in the holding register, and buf_empty_o stays 0 while it waits. On the edge that ends the current word, the waiting word is loaded and its bit 0 is driven with no idle bit in between. buf_empty_o then returns to 1.
- R6: irq_o equals buf_empty_o AND irq_en_i.
- R7: shift_empty_o is 1 exactly when no word is being shifted. It returns to 1 after the last bit's selected edge when no word is waiting.
- R8: After reset, data_o=1, buf_empty_o=1, shift_empty_o=1 and irq_o=0 while irq_en_i=0.
- R9: data_o is 1 whenever no word is being shifted.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | Synchronous mode select |
| port_en_i | input | 1 | Serial port enable |
| clk_master_i | input | 1 | Clock source select, 1 = internal master clock (transmitter inactive) |
| rx_cont_i | input | 1 | Continuous receive enable, must be 0 |
| rx_single_i | input | 1 | Single receive enable, must be 0 |
| tx_en_i | input | 1 | Transmit enable |
| nine_bit_i | input | 1 | Nine-bit word select, sampled at write |
| bit9_i | input | 1 | Ninth data bit, sampled at write |
| clk_pol_i | input | 1 | 0 = shift on falling external edge, 1 = shift on rising external edge |
| irq_en_i | input | 1 | Buffer-empty interrupt enable |
| ext_clk_i | input | 1 | External shift clock, asynchronous |
| wr_i | input | 1 | Write strobe for the holding register |
| wdata_i | input | 8 | Write data |
| data_o | output | 1 | Serial data line |
| buf_empty_o | output | 1 | Holding register free flag |
| irq_o | output | 1 | Interrupt / wake request |
| shift_empty_o | output | 1 | Shift register idle status |

## Verification
On every cycle the assertions check several cycle-level properties. A handoff always finds a valid waiting word. A waiting word is not lost without a handoff. Each selected edge moves the bit count down by exactly one. The synchronised edge pulse lasts one cycle. Any exit from the active mode empties the shifter, and the interrupt never fires without its enable. Only the bench's scenarios can show the properties that need the external clock to run: the serial bit order under both polarities, the captured ninth bit, the flag staying low across a whole queued word and the back-to-back handoff, and the abort in the middle of a word.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned WORD_W = DATA_W + 1;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/sstx_edge_sync.sv
module sstx_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  input  logic pol_i,
  output logic shift_edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
  assign fall = ~chain_q[STAGES-1] & prev_q;
  assign shift_edge_o = pol_i ? rise : fall;

  // edge pulse lasts a single system cycle
  p_edge_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise || fall) |=> !(rise || fall));
endmodule

// File: rtl/sstx_holding.sv
module sstx_holding
  import sstx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bit9_i,
  input  logic              nine_i,
  input  logic              take_i,
  output logic              valid_o,
  output word_t             word_o,
  output logic              nine_o
);
  logic  valid_q;
  word_t word_q;
  logic  nine_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      word_q  <= '0;
      nine_q  <= 1'b0;
    end else if (clear_i) begin
      valid_q <= 1'b0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      word_q  <= {bit9_i, wdata_i};
      nine_q  <= nine_i;
    end else if (take_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign word_o  = word_q;
  assign nine_o  = nine_q;

  p_take_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> valid_q);
  p_wait_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !take_i && !clear_i) |=> valid_q);
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter
  import sstx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  active_i,
  input  logic  edge_i,
  input  logic  hold_valid_i,
  input  word_t hold_word_i,
  input  logic  hold_nine_i,
  output logic  take_o,
  output logic  busy_o,
  output logic  data_o
);
  word_t sh_q;
  cnt_t  cnt_q;
  logic  busy_q;
  logic  last;

  assign last   = (cnt_q == cnt_t'(1));
  assign take_o = active_i & hold_valid_i & (~busy_q | (edge_i & last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!active_i) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (take_o) begin
      sh_q   <= hold_word_i;
      cnt_q  <= hold_nine_i ? cnt_t'(WORD_W) : cnt_t'(DATA_W);
      busy_q <= 1'b1;
    end else if (busy_q && edge_i) begin
      if (last) begin
        sh_q   <= '1;
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        sh_q  <= {1'b1, sh_q[WORD_W-1:1]};
        cnt_q <= cnt_q - cnt_t'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign data_o = busy_q ? sh_q[0] : 1'b1;

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q >= cnt_t'(1) && cnt_q <= cnt_t'(WORD_W)));
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && busy_q && edge_i && !last) |=> (busy_q && cnt_q == $past(cnt_q) - cnt_t'(1)));
  p_abort_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !busy_q);
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
  import sstx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_mode_i,
  input  logic              port_en_i,
  input  logic              clk_master_i,
  input  logic              rx_cont_i,
  input  logic              rx_single_i,
  input  logic              tx_en_i,
  input  logic              nine_bit_i,
  input  logic              bit9_i,
  input  logic              clk_pol_i,
  input  logic              irq_en_i,
  input  logic              ext_clk_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              data_o,
  output logic              buf_empty_o,
  output logic              irq_o,
  output logic              shift_empty_o
);
  logic  active, shift_edge, take, hold_valid, hold_nine, busy;
  word_t hold_word;

  assign active = sync_mode_i & port_en_i & ~clk_master_i &
                  ~rx_cont_i & ~rx_single_i & tx_en_i;

  sstx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(ext_clk_i), .pol_i(clk_pol_i), .shift_edge_o(shift_edge)
  );

  sstx_holding u_hold (
    .clk_i, .rst_ni, .clear_i(~active), .wr_i, .wdata_i, .bit9_i,
    .nine_i(nine_bit_i), .take_i(take), .valid_o(hold_valid),
    .word_o(hold_word), .nine_o(hold_nine)
  );

  sstx_shifter u_shift (
    .clk_i, .rst_ni, .active_i(active), .edge_i(shift_edge),
    .hold_valid_i(hold_valid), .hold_word_i(hold_word), .hold_nine_i(hold_nine),
    .take_o(take), .busy_o(busy), .data_o
  );

  assign buf_empty_o   = ~hold_valid;
  assign irq_o         = buf_empty_o & irq_en_i;
  assign shift_empty_o = ~busy;

  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i);
  p_idle_line_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_empty_o |-> data_o);
endmodule

// File: tb/sync_slave_tx_tb_top.sv
module sync_slave_tx_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sync_mode, port_en, clk_master, rx_cont, rx_single, tx_en;
  logic nine_bit, bit9, clk_pol, irq_en, ext_clk, wr;
  logic [7:0] wdata;
  logic data_o, buf_empty_o, irq_o, shift_empty_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_slave_tx dut_i (
    .clk_i(clk), .rst_ni, .sync_mode_i(sync_mode), .port_en_i(port_en),
    .clk_master_i(clk_master), .rx_cont_i(rx_cont), .rx_single_i(rx_single),
    .tx_en_i(tx_en), .nine_bit_i(nine_bit), .bit9_i(bit9), .clk_pol_i(clk_pol),
    .irq_en_i(irq_en), .ext_clk_i(ext_clk), .wr_i(wr), .wdata_i(wdata),
    .data_o, .buf_empty_o, .irq_o, .shift_empty_o
  );

  // {pol, nine, bit9, data}
  localparam logic [10:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5}, {1'b0, 1'b0, 1'b1, 8'h01},
    {1'b1, 1'b0, 1'b0, 8'h80}, {1'b1, 1'b1, 1'b1, 8'h5A},
    {1'b0, 1'b1, 1'b0, 8'hFF}, {1'b0, 1'b1, 1'b1, 8'h00}
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pol(input logic p);
    clk_pol = p;
    ext_clk = p;
    cyc(HALF);
  endtask

  task automatic write(input logic [7:0] d);
    wdata = d; wr = 1'b1;
    cyc(1);
    wr = 1'b0;
  endtask

  // sample current bit, then give one selected edge
  task automatic one_bit(output logic b);
    ext_clk = ~clk_pol;
    cyc(HALF);
    b = data_o;
    ext_clk = clk_pol;
    cyc(HALF);
  endtask

  task automatic clock_word(input int n, output logic [8:0] got);
    got = '1;
    for (int i = 0; i < n; i++) begin
      logic b;
      one_bit(b);
      got[i] = b;
    end
  endtask

  initial begin
    logic [8:0] got;
    logic b;
    sync_mode = 1; port_en = 1; clk_master = 0; rx_cont = 0; rx_single = 0;
    tx_en = 1; nine_bit = 0; bit9 = 0; clk_pol = 0; irq_en = 0;
    ext_clk = 0; wr = 0; wdata = '0;
    cyc(3);
    // R8 reset state
    chk("R8 data_o", 9'(data_o), 9'd1);
    chk("R8 buf_empty", 9'(buf_empty_o), 9'd1);
    chk("R8 shift_empty", 9'(shift_empty_o), 9'd1);
    chk("R8 irq", 9'(irq_o), 9'd0);
    rst_ni = 1'b1;
    cyc(HALF);

    // R3 R4 table of frames
    foreach (VEC[k]) begin
      set_pol(VEC[k][10]);
      nine_bit = VEC[k][9]; bit9 = VEC[k][8];
      write(VEC[k][7:0]);
      bit9 = ~VEC[k][8];  // R4 ninth bit latched at write
      cyc(2);
      chk("R2 shift_empty after load", 9'(shift_empty_o), 9'd0);
      clock_word(VEC[k][9] ? 9 : 8, got);
      if (VEC[k][9]) chk("R3 R4 nine-bit frame", got, VEC[k][8:0]);
      else           chk("R3 eight-bit frame", {1'b1, got[7:0]}, {1'b1, VEC[k][7:0]});
      chk("R7 idle after frame", 9'(shift_empty_o), 9'd1);
      chk("R9 line idle", 9'(data_o), 9'd1);
    end

    // R5 R6 double buffering
    set_pol(1'b0);
    nine_bit = 0; irq_en = 1;
    write(8'hC3);
    cyc(2);
    chk("R5 flag set after direct load", 9'(buf_empty_o), 9'd1);
    chk("R6 irq with enable", 9'(irq_o), 9'd1);
    write(8'h3C);
    cyc(1);
    chk("R5 flag clear while waiting", 9'(buf_empty_o), 9'd0);
    chk("R6 irq low while waiting", 9'(irq_o), 9'd0);
    clock_word(7, got);
    chk("R5 flag still clear at bit 7", 9'(buf_empty_o), 9'd0);
    one_bit(b);
    got[7] = b;
    chk("R5 first word", {1'b1, got[7:0]}, 9'h1C3);
    chk("R5 flag set at handoff", 9'(buf_empty_o), 9'd1);
    chk("R6 irq at handoff", 9'(irq_o), 9'd1);
    chk("R5 no idle gap", 9'(shift_empty_o), 9'd0);
    clock_word(8, got);
    chk("R5 second word", {1'b1, got[7:0]}, 9'h13C);
    chk("R7 empty after both", 9'(shift_empty_o), 9'd1);
    irq_en = 0;
    cyc(1);
    chk("R6 irq off without enable", 9'(irq_o), 9'd0);

    // R1 writes ignored while inactive
    tx_en = 0; write(8'h00); cyc(2); tx_en = 1; cyc(3);
    chk("R1 tx_en low ignores write", {7'd0, shift_empty_o, data_o}, 9'd3);
    clk_master = 1; write(8'h00); cyc(2); clk_master = 0; cyc(3);
    chk("R1 master clock ignores write", {7'd0, shift_empty_o, data_o}, 9'd3);
    rx_cont = 1; write(8'h00); cyc(2); rx_cont = 0; cyc(3);
    chk("R1 receive enable ignores write", {7'd0, shift_empty_o, data_o}, 9'd3);

    // R1 abort mid-word
    write(8'h00);
    cyc(2);
    clock_word(3, got);
    chk("R3 zero bits driven", 9'(data_o), 9'd0);
    tx_en = 0;
    cyc(2);
    chk("R1 abort empties shifter", {7'd0, shift_empty_o, data_o}, 9'd3);
    tx_en = 1;
    cyc(2);
    clock_word(2, got);
    chk("R1 no resume after abort", {7'd0, shift_empty_o, data_o}, 9'd3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule